// File: doc/BRIEF.md
# Addressed Serial DAC Frame Receiver

This block receives 24-bit serial write frames for a bank of four 14-bit DAC channels. A frame lies inside one low period of an active-low frame sync. One bit is taken on each falling edge of the serial clock, most significant bit first. Each frame carries a 5-bit package address, a broadcast flag, a 2-bit channel select, two reserved bits and a 14-bit data word. The package address is compared with five strap inputs, so up to 32 receivers can share one serial bus. When the strap enable is low, the comparison is skipped. A frame with the wrong length is dropped whole.

Accepted data goes into the addressed channel's input register. With the broadcast flag set, it goes into all four input registers. Each input register feeds a DAC latch behind it. A low load strobe copies the input registers into the latches. A low clear input forces the outputs into the cleared state and blocks the load strobe. After clear is released, the outputs stay cleared until the load strobe goes low again. All serial and control inputs are sampled by the block's own clock through synchronizer stages, so that clock must run several times faster than the serial clock.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, all four input registers and all four DAC latches read zero, and `out_cleared` is 1.
- R2: A frame is the falling `sclk` edges seen while `fsync_n` is low, taken MSB first and closed by the rise of `fsync_n`. With exactly 24 edges, bits [13:0] are written to the input register picked by bits [17:16] (channel n sits at `in_q[14n +: 14]`). Without an accepted frame, no input register changes.
- R3: With `strap_en` high, a frame is accepted only when bits [23:19] equal `strap_addr`; any other frame writes nothing.
- R4: With `strap_en` low, every 24-bit frame is accepted whatever its bits [23:19] hold.
- R5: A frame with fewer than 24 falling edges writes nothing.
- R6: A frame with more than 24 falling edges writes nothing.
- R7: When bit 18 of an accepted frame is 1, the data is written to all four input registers, whatever bits [17:16] hold.
- R8: While `load_n` is high, the DAC latches (`dac_q`, channel n at `[14n +: 14]`) do not change, even when input registers are written.
- R9: While `load_n` is low and `clear_n` is high, every DAC latch takes its input register's value, and `out_cleared` goes to 0.
- R10: If `load_n` is already low when a valid frame completes, the addressed DAC latch takes the new data together with its input register.
- R11: While `clear_n` is low, `out_cleared` is 1 and `load_n` has no effect on the DAC latches.
- R12: After `clear_n` returns high, `out_cleared` stays 1 until `load_n` is next low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_n | input | 1 | Active-low frame sync |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| sdin | input | 1 | Serial data |
| strap_addr | input | 5 | Package address straps |
| strap_en | input | 1 | High enables package address comparison |
| load_n | input | 1 | Active-low level load strobe |
| clear_n | input | 1 | Active-low clear |
| in_q | output | 56 | Four 14-bit input registers, channel 0 lowest |
| dac_q | output | 56 | Four 14-bit DAC latches, channel 0 lowest |
| out_cleared | output | 1 | High while the outputs are in the cleared state |

## Verification
The main function is driven from a vector table of frames that differ in one respect each. A matching address writes one channel. Writes to channels 0 and 3 show that the select bits are decoded in place. A foreign address is sent once with the strap enable high and once with it low, which separates a rejected frame from a bypassed comparison. Frames of 20 and 25 bits separate the short-frame check from the overlong one, and a broadcast frame with select 0 shows that the flag overrides the select. Directed sequences follow, covering load held high, load held low across a frame, clear with a load pulse inside it, and release of clear before and after the next load.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_W     = 5;
  localparam int CH_W       = 2;
  localparam int NCH        = 1 << CH_W;
  localparam int DATA_W     = 14;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int CNT_OVER   = FRAME_BITS + 1;
  localparam int POS_PKG    = FRAME_BITS - ADDR_W;
  localparam int POS_BC     = POS_PKG - 1;
  localparam int POS_CH     = POS_BC - CH_W;

  typedef struct packed {
    logic [ADDR_W-1:0] pkg;
    logic              bcast;
    logic [CH_W-1:0]   ch;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift
  import sdac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fs_n,
  input  logic sck,
  input  logic sd,
  output cmd_t cmd,
  output logic cmd_vld
);
  logic                  fs_q, sck_q;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  vld_q, vld_d;
  cmd_t                  cmd_q, cmd_d;
  logic                  fs_fall, fs_rise, sck_fall;

  assign fs_fall  = fs_q & ~fs_n;
  assign fs_rise  = ~fs_q & fs_n;
  assign sck_fall = sck_q & ~sck;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (fs_fall) begin
      cnt_d = '0;
    end else if (!fs_n && sck_fall) begin
      sh_d = {sh_q[FRAME_BITS-2:0], sd};
      if (cnt_q != CNT_W'(CNT_OVER)) cnt_d = cnt_q + 1'b1;
    end
    vld_d = fs_rise && (cnt_q == CNT_W'(FRAME_BITS));
    cmd_d.pkg   = sh_q[POS_PKG +: ADDR_W];
    cmd_d.bcast = sh_q[POS_BC];
    cmd_d.ch    = sh_q[POS_CH +: CH_W];
    cmd_d.data  = sh_q[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b1;
      sck_q <= 1'b1;
      cnt_q <= CNT_W'(CNT_OVER);
      sh_q  <= '0;
      vld_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      fs_q  <= fs_n;
      sck_q <= sck;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
      if (vld_d) cmd_q <= cmd_d;
    end
  end

  assign cmd     = cmd_q;
  assign cmd_vld = vld_q;
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank
  import sdac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic                    bcast,
  input  logic [CH_W-1:0]         ch,
  input  logic [DATA_W-1:0]       data,
  input  logic                    ld_n,
  input  logic                    clr_n,
  output logic [NCH*DATA_W-1:0]   in_flat,
  output logic [NCH*DATA_W-1:0]   lat_flat,
  output logic                    cleared
);
  logic load_all;
  logic clr_q, clr_d;

  assign load_all = ~ld_n & clr_n;

  always_comb begin
    clr_d = clr_q;
    if (!clr_n)     clr_d = 1'b1;
    else if (!ld_n) clr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b1;
    else        clr_q <= clr_d;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DATA_W-1:0] in_q, in_d, lat_q, lat_d;
    logic              hit;

    always_comb begin
      hit   = wr & (bcast | (ch == CH_W'(i)));
      in_d  = hit ? data : in_q;
      lat_d = load_all ? in_d : lat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        lat_q <= '0;
      end else begin
        in_q  <= in_d;
        lat_q <= lat_d;
      end
    end

    assign in_flat[i*DATA_W +: DATA_W]  = in_q;
    assign lat_flat[i*DATA_W +: DATA_W] = lat_q;
  end

  assign cleared = clr_q;
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync_n,
  input  logic                  sclk,
  input  logic                  sdin,
  input  logic [ADDR_W-1:0]     strap_addr,
  input  logic                  strap_en,
  input  logic                  load_n,
  input  logic                  clear_n,
  output logic [NCH*DATA_W-1:0] in_q,
  output logic [NCH*DATA_W-1:0] dac_q,
  output logic                  out_cleared
);
  logic [4:0] raw_in, syn;
  logic       fs_s, sck_s, sd_s, ld_s, clr_s;
  cmd_t       cmd;
  logic       frame_done, accept;

  assign raw_in = {clear_n, load_n, sdin, sclk, fsync_n};

  sdac_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b01011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign {clr_s, ld_s, sd_s, sck_s, fs_s} = syn;

  sdac_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .fs_n(fs_s), .sck(sck_s), .sd(sd_s),
    .cmd(cmd), .cmd_vld(frame_done)
  );

  assign accept = frame_done & (~strap_en | (cmd.pkg == strap_addr));

  sdac_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr(accept), .bcast(cmd.bcast), .ch(cmd.ch),
    .data(cmd.data), .ld_n(ld_s), .clr_n(clr_s),
    .in_flat(in_q), .lat_flat(dac_q), .cleared(out_cleared)
  );
endmodule

// File: rtl/sdac_frame_rx_chk.sv
module sdac_frame_rx_chk
  import sdac_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ld_s,
  input logic                  clr_s,
  input logic                  frame_done,
  input logic [NCH*DATA_W-1:0] in_q,
  input logic [NCH*DATA_W-1:0] dac_q,
  input logic                  out_cleared
);
  // R2
  in_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(in_q));
  // R8
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(dac_q));
  // R9
  load_uncleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_s && clr_s) |=> !out_cleared);
  // R11
  clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> out_cleared);
  // R11
  clear_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> $stable(dac_q));
  // R12
  clear_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && ld_s && out_cleared) |=> out_cleared);
endmodule

bind sdac_frame_rx sdac_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_s(ld_s), .clr_s(clr_s),
  .frame_done(frame_done), .in_q(in_q), .dac_q(dac_q),
  .out_cleared(out_cleared)
);

// File: tb/sdac_frame_rx_test.sv
module sdac_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int NV         = 8;
  localparam logic [4:0] MY_ADDR = 5'h15;

  // entry: pkg[29:25] bc[24] ch[23:22] data[21:8] nbits[7:2] en[1] accept[0]
  localparam logic [29:0] VEC [NV] = '{
    {5'h15, 1'b0, 2'd0, 14'h1234, 6'd24, 1'b1, 1'b1},  // R2 ch0
    {5'h15, 1'b0, 2'd3, 14'h3FFF, 6'd24, 1'b1, 1'b1},  // R2 ch3
    {5'h0A, 1'b0, 2'd1, 14'h0AAA, 6'd24, 1'b1, 1'b0},  // R3 mismatch
    {5'h0A, 1'b0, 2'd1, 14'h0555, 6'd24, 1'b0, 1'b1},  // R4 bypass
    {5'h15, 1'b0, 2'd2, 14'h2222, 6'd20, 1'b1, 1'b0},  // R5 short
    {5'h15, 1'b0, 2'd2, 14'h3333, 6'd25, 1'b1, 1'b0},  // R6 long
    {5'h15, 1'b1, 2'd0, 14'h0F0F, 6'd24, 1'b1, 1'b1},  // R7 broadcast
    {5'h15, 1'b0, 2'd2, 14'h1001, 6'd24, 1'b1, 1'b1}   // R2 ch2
  };

  logic        clk = 1'b0;
  logic        rst_n, fsync_n, sclk, sdin, strap_en, load_n, clear_n;
  logic [4:0]  strap_addr;
  logic [55:0] in_q, dac_q;
  logic        out_cleared;

  int tests = 0;
  int fails = 0;
  logic [13:0] exp_in [4];
  logic [13:0] exp_lat [4];
  logic        exp_clr;

  sdac_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .sclk(sclk), .sdin(sdin),
    .strap_addr(strap_addr), .strap_en(strap_en), .load_n(load_n),
    .clear_n(clear_n), .in_q(in_q), .dac_q(dac_q), .out_cleared(out_cleared)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) begin
      tests++;
      if (in_q[i*14 +: 14] !== exp_in[i]) begin
        fails++;
        $display("FAIL %s in ch%0d got %h exp %h", req, i, in_q[i*14 +: 14], exp_in[i]);
      end
      tests++;
      if (dac_q[i*14 +: 14] !== exp_lat[i]) begin
        fails++;
        $display("FAIL %s dac ch%0d got %h exp %h", req, i, dac_q[i*14 +: 14], exp_lat[i]);
      end
    end
    tests++;
    if (out_cleared !== exp_clr) begin
      fails++;
      $display("FAIL %s cleared got %b exp %b", req, out_cleared, exp_clr);
    end
  endtask

  task automatic send(input logic [23:0] w, input int nb);
    fsync_n = 1'b0;
    wait_clk(HALF_SCK);
    for (int b = 0; b < nb; b++) begin
      sclk = 1'b1;
      sdin = (b < 24) ? w[23-b] : 1'b0;
      wait_clk(HALF_SCK);
      sclk = 1'b0;
      wait_clk(HALF_SCK);
    end
    sclk = 1'b1;
    wait_clk(HALF_SCK);
    fsync_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic model_write(input logic bc, input logic [1:0] ch, input logic [13:0] d);
    for (int i = 0; i < 4; i++)
      if (bc || ch == 2'(i)) exp_in[i] = d;
    if (!load_n && clear_n)
      for (int i = 0; i < 4; i++) exp_lat[i] = exp_in[i];
  endtask

  task automatic pulse_load;
    load_n = 1'b0;
    wait_clk(6);
    load_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    for (int i = 0; i < 4; i++) begin
      exp_in[i] = '0;
      exp_lat[i] = '0;
    end
    exp_clr = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    fsync_n = 1'b1; sclk = 1'b1; sdin = 1'b0;
    strap_addr = MY_ADDR; strap_en = 1'b1;
    load_n = 1'b1; clear_n = 1'b1;
    do_reset();
    check_all("R1 reset");

    for (int v = 0; v < NV; v++) begin
      logic [29:0] e;
      e = VEC[v];
      strap_en = e[1];
      send({e[29:25], e[24], e[23:22], 2'b00, e[21:8]}, int'(e[7:2]));
      if (e[0]) model_write(e[24], e[23:22], e[21:8]);
      check_all($sformatf("R2/R3/R4/R5/R6/R7/R8 vec%0d", v));
    end
    strap_en = 1'b1;

    // R9: load copies all and uncleared
    pulse_load();
    for (int i = 0; i < 4; i++) exp_lat[i] = exp_in[i];
    exp_clr = 1'b0;
    check_all("R9 load");

    // R8: write with load high leaves latches
    send({MY_ADDR, 1'b0, 2'd1, 2'b00, 14'h0777}, 24);
    model_write(1'b0, 2'd1, 14'h0777);
    check_all("R8 hold");

    // R10: load low across frame
    load_n = 1'b0;
    wait_clk(6);
    for (int i = 0; i < 4; i++) exp_lat[i] = exp_in[i];
    send({MY_ADDR, 1'b0, 2'd0, 2'b00, 14'h2468}, 24);
    model_write(1'b0, 2'd0, 14'h2468);
    check_all("R10 immediate");
    load_n = 1'b1;
    wait_clk(6);

    // R11: clear forces and blocks load
    clear_n = 1'b0;
    wait_clk(6);
    exp_clr = 1'b1;
    check_all("R11 clear");
    send({MY_ADDR, 1'b0, 2'd3, 2'b00, 14'h1111}, 24);
    model_write(1'b0, 2'd3, 14'h1111);
    pulse_load();
    check_all("R11 load ignored");

    // R12: release keeps cleared until load
    clear_n = 1'b1;
    wait_clk(8);
    check_all("R12 sticky");
    pulse_load();
    for (int i = 0; i < 4; i++) exp_lat[i] = exp_in[i];
    exp_clr = 1'b0;
    check_all("R12 load release");

    // R1: reset mid-run
    do_reset();
    check_all("R1 second reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule